// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside an SDRAM controller and follows the command stream sent to a two-bank memory. It decodes the chip select, row strobe, column strobe and write enable on every clock. From that stream it keeps a state for each bank: idle, open, open with a scheduled self-timed close, or closing. It measures the row-open time of each bank against a minimum and a maximum. It counts out the close-recovery time. When a read or write asks for an automatic close, it runs that close without a visible command.

Timing limits are elaboration parameters counted in clock cycles. Burst length and read latency are static inputs, since the tracker does not decode the mode register. All violation outputs are registered one-cycle pulses. A pulse appears in the cycle after the clock edge that sampled the offending command, so a monitor or a controller under test can count errors directly.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After a synchronous reset every bank reports code 00 (idle), `all_idle` is 1 and every violation output is 0.
- R2: An activate to a ready bank sets that bank to code 01 (open). A bank is ready when it is idle, or when it is closing and in its last recovery cycle. An activate to a bank that is not ready pulses `viol_cmd` and leaves the state unchanged.
- R3: A read or write with `a10` low keeps an open bank at code 01 until another command arrives. A read or write to a bank that is not at code 01 pulses `viol_cmd` and is ignored.
- R4: A read or write with `a10` high moves the bank to code 11. The hidden close (code 10) then starts at the later of two edges: the command edge plus `burst_len`+`cas_lat`, and the activate edge plus `T_RAS_MIN`.
- R5: While a bank is at code 11, any activate, read, write or precharge that reaches it pulses `viol_cmd` and leaves its scheduled close unchanged. This includes a precharge-all.
- R6: A precharge with `a10` high moves every bank at code 01 to code 10. With `a10` low, only the bank chosen by `bank_sel` moves. A precharge to an idle bank has no effect.
- R7: A bank that starts closing at edge p returns to code 00 at edge p+`T_RP`. An activate on that same edge is legal.
- R8: A precharge to a bank at code 01 that comes fewer than `T_RAS_MIN` edges after its activate pulses `viol_cmd`. The bank still starts closing.
- R9: If a bank is still open (01 or 11) at edge a+`T_RAS_MAX`+1, where a is its activate edge, its bit of `viol_tras_max` pulses once for that activation.
- R10: Refresh (cs 0, ras 0, cas 0, we 1), mode-register set (all four strobes 0) and power-down entry pulse `viol_idle_only` unless every bank is ready. Power-down entry means `cke` falls while the command is a no-op or a deselect. Any command sampled while `cke` was low on the previous edge is ignored.
- R11: `all_idle` is 1 exactly when every bank reports code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable as seen by the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-close on read/write, all-banks on precharge |
| bank_sel | input | BA_W | Bank address |
| burst_len | input | BL_W | Static burst length in beats |
| cas_lat | input | CL_W | Static read latency in cycles |
| bank_state | output | 2*NUM_BANKS | Per-bank state code: 00 idle, 01 open, 11 open with close scheduled, 10 closing |
| all_idle | output | 1 | Every bank idle |
| viol_cmd | output | 1 | Pulse: illegal command to a bank |
| viol_idle_only | output | 1 | Pulse: all-idle command issued with a bank not ready |
| viol_tras_max | output | NUM_BANKS | Pulse per bank: row open too long |

## Verification
The bank machine is driven through a cycle table that interleaves both banks. That table separates bank-select decoding from shared precharge-all behaviour, and recovery-edge reactivation from early reactivation. Directed runs of automatic close use both short and long bursts. The short burst shows whether the minimum row-open time or the burst-plus-latency count decides the close edge. A precharge-all issued while one bank has a scheduled close checks that the locked bank keeps its own timing while the other bank closes. A long open window shows that the maximum-time pulse fires on exactly one edge. A power-down sequence shows that commands sampled with the clock enable low are not tracked.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  // Code values are visible at the ports: 00 idle, 01 open, 11 open with close scheduled, 10 closing.
  typedef enum logic [1:0] {
    BK_IDLE    = 2'b00,
    BK_OPEN    = 2'b01,
    BK_CLOSING = 2'b10,
    BK_OPEN_AP = 2'b11
  } bank_st_e;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return CMD_NOP;
    case ({ras_n, cas_n, we_n})
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      3'b000:  return CMD_MRS;
      3'b110:  return CMD_BST;
      default: return CMD_NOP;
    endcase
  endfunction

  // Cycles from a read/write with auto close to the earliest hidden close edge.
  function automatic logic [8:0] ap_wait(input logic [7:0] bl, input logic [3:0] cl);
    return {1'b0, bl} + 9'(cl);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd,
  output logic pd_entry
);

  logic cke_q;
  cmd_e raw_cmd;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end

  assign raw_cmd  = decode_cmd(cs_n, ras_n, cas_n, we_n);
  // With the clock enable low on the previous edge the memory ignores its inputs.
  assign cmd      = cke_q ? raw_cmd : CMD_NOP;
  assign pd_entry = cke_q && !cke && (raw_cmd == CMD_NOP);

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int T_RAS_MIN = 4,
  parameter int T_RAS_MAX = 20,
  parameter int T_RP      = 3,
  parameter int APW       = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  cmd_e           cmd,
  input  logic           hit,
  input  logic           a10,
  input  logic [APW-1:0] ap_delay,
  output bank_st_e       st,
  output logic           ready,
  output logic           viol_cmd,
  output logic           viol_tras
);

  localparam int RW = $clog2(T_RAS_MAX + 2);
  localparam int PW = (T_RP > 1) ? $clog2(T_RP) : 1;

  logic [RW-1:0]  row_cnt;
  logic [APW-1:0] ap_cnt;
  logic [PW-1:0]  rp_cnt;

  // Named internal events, shared by the next-state logic and the assertions.
  logic act_hit, rw_hit, pre_hit, is_open, ras_ok, ap_due, tras_hit, bad_cmd;

  function automatic logic min_row_met(input logic [RW-1:0] r);
    return (int'(r) + 1) >= T_RAS_MIN;
  endfunction

  assign act_hit  = hit && (cmd == CMD_ACT);
  assign rw_hit   = hit && (cmd == CMD_RD || cmd == CMD_WR);
  assign pre_hit  = (cmd == CMD_PRE) && (a10 || hit);
  assign ready    = (st == BK_IDLE) || (st == BK_CLOSING && rp_cnt == '0);
  assign is_open  = (st == BK_OPEN) || (st == BK_OPEN_AP);
  assign ras_ok   = min_row_met(row_cnt);
  assign ap_due   = (st == BK_OPEN_AP) && (ap_cnt <= APW'(1)) && ras_ok;
  assign tras_hit = is_open && (row_cnt == RW'(T_RAS_MAX));
  assign bad_cmd  = (act_hit && !ready)
                 || (rw_hit && st != BK_OPEN)
                 || (pre_hit && st == BK_OPEN_AP)
                 || (pre_hit && st == BK_OPEN && !ras_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BK_IDLE;
      row_cnt   <= '0;
      ap_cnt    <= '0;
      rp_cnt    <= '0;
      viol_cmd  <= 1'b0;
      viol_tras <= 1'b0;
    end else begin
      viol_cmd  <= bad_cmd;
      viol_tras <= tras_hit;
      if (is_open && row_cnt <= RW'(T_RAS_MAX)) row_cnt <= row_cnt + 1'b1;
      unique case (st)
        BK_IDLE: begin
          if (act_hit) begin
            st      <= BK_OPEN;
            row_cnt <= '0;
          end
        end
        BK_OPEN: begin
          if (pre_hit) begin
            st     <= BK_CLOSING;
            rp_cnt <= PW'(T_RP - 1);
          end else if (rw_hit && a10) begin
            st     <= BK_OPEN_AP;
            ap_cnt <= ap_delay;
          end
        end
        BK_OPEN_AP: begin
          if (ap_due) begin
            st     <= BK_CLOSING;
            rp_cnt <= PW'(T_RP - 1);
          end else if (ap_cnt != '0) begin
            ap_cnt <= ap_cnt - 1'b1;
          end
        end
        BK_CLOSING: begin
          if (rp_cnt == '0) begin
            if (act_hit) begin
              st      <= BK_OPEN;
              row_cnt <= '0;
            end else begin
              st <= BK_IDLE;
            end
          end else begin
            rp_cnt <= rp_cnt - 1'b1;
          end
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (st == BK_IDLE) |=> (st == BK_IDLE || st == BK_OPEN));

  assert_ap_min_row_R4: assert property (@(posedge clk) disable iff (rst)
    (st == BK_CLOSING && $past(st) == BK_OPEN_AP) |-> ((int'($past(row_cnt)) + 1) >= T_RAS_MIN));

  assert_ap_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (st == BK_OPEN_AP) |=> (st == BK_OPEN_AP || st == BK_CLOSING));

  assert_recovery_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (st == BK_CLOSING && rp_cnt != '0) |=> (st == BK_CLOSING));

  assert_tras_single_R9: assert property (@(posedge clk) disable iff (rst)
    viol_tras |=> !viol_tras);

  assert_row_bound_R9: assert property (@(posedge clk) disable iff (rst)
    int'(row_cnt) <= T_RAS_MAX + 1);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int T_RAS_MIN = 4,
  parameter int T_RAS_MAX = 20,
  parameter int T_RP      = 3,
  parameter int BL_W      = 4,
  parameter int CL_W      = 2,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic                   a10,
  input  logic [BA_W-1:0]        bank_sel,
  input  logic [BL_W-1:0]        burst_len,
  input  logic [CL_W-1:0]        cas_lat,
  output logic [2*NUM_BANKS-1:0] bank_state,
  output logic                   all_idle,
  output logic                   viol_cmd,
  output logic                   viol_idle_only,
  output logic [NUM_BANKS-1:0]   viol_tras_max
);

  localparam int APW = 9;

  cmd_e           cmd;
  logic           pd_entry;
  logic [APW-1:0] ap_delay;
  logic [NUM_BANKS-1:0] ready_vec, idle_vec, vc_vec;
  logic           global_req;

  sdram_cmd_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cmd      (cmd),
    .pd_entry (pd_entry)
  );

  assign ap_delay = ap_wait(8'(burst_len), 4'(cas_lat));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bank_st_e st_i;
    logic     hit_i;

    assign hit_i = (bank_sel == BA_W'(i));

    sdram_bank_fsm #(
      .T_RAS_MIN (T_RAS_MIN),
      .T_RAS_MAX (T_RAS_MAX),
      .T_RP      (T_RP),
      .APW       (APW)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .cmd       (cmd),
      .hit       (hit_i),
      .a10       (a10),
      .ap_delay  (ap_delay),
      .st        (st_i),
      .ready     (ready_vec[i]),
      .viol_cmd  (vc_vec[i]),
      .viol_tras (viol_tras_max[i])
    );

    assign bank_state[2*i +: 2] = st_i;
    assign idle_vec[i]          = (st_i == BK_IDLE);
  end

  assign all_idle   = &idle_vec;
  assign viol_cmd   = |vc_vec;
  assign global_req = (cmd == CMD_REF) || (cmd == CMD_MRS) || pd_entry;

  always_ff @(posedge clk) begin
    if (rst) viol_idle_only <= 1'b0;
    else     viol_idle_only <= global_req && !(&ready_vec);
  end

  assert_idle_flag_R11: assert property (@(posedge clk) disable iff (rst)
    all_idle |=> (viol_cmd == 1'b0 || $past(cmd) != CMD_PRE));

  assert_legal_global_R10: assert property (@(posedge clk) disable iff (rst)
    (all_idle && global_req) |=> !viol_idle_only);

endmodule

// File: tb/tb_sdram_bank_tracker.sv
`timescale 1ns/1ps
module tb_sdram_bank_tracker;

  localparam int TRMIN = 4;
  localparam int TRMAX = 20;
  localparam int TRP   = 3;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6;

  logic clk = 1'b0;
  logic rst, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [0:0] bank_sel;
  logic [3:0] burst_len;
  logic [1:0] cas_lat;
  logic [3:0] bank_state;
  logic all_idle, viol_cmd, viol_idle_only;
  logic [1:0] viol_tras_max;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sdram_bank_tracker #(.T_RAS_MIN(TRMIN), .T_RAS_MAX(TRMAX), .T_RP(TRP)) dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .a10(a10), .bank_sel(bank_sel), .burst_len(burst_len),
    .cas_lat(cas_lat), .bank_state(bank_state), .all_idle(all_idle),
    .viol_cmd(viol_cmd), .viol_idle_only(viol_idle_only), .viol_tras_max(viol_tras_max)
  );

  // Row: {command, a10, bank, expected {bank1,bank0} codes, viol_cmd, viol_idle_only}
  localparam int NV = 25;
  localparam logic [10:0] VEC [NV] = '{
    {C_ACT, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b0},
    {C_RD,  1'b0, 1'b0, 4'b0001, 1'b0, 1'b0},
    {C_ACT, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b0},
    {C_ACT, 1'b0, 1'b1, 4'b0101, 1'b0, 1'b0},
    {C_PRE, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0},
    {C_ACT, 1'b0, 1'b0, 4'b0101, 1'b0, 1'b0},
    {C_RD,  1'b1, 1'b1, 4'b1101, 1'b0, 1'b0},
    {C_RD,  1'b0, 1'b1, 4'b1101, 1'b1, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b1101, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b1101, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b1001, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b1001, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b1001, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b0},
    {C_REF, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b1},
    {C_PRE, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0},
    {C_MRS, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0},
    {C_REF, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0},
    {C_WR,  1'b0, 1'b1, 4'b0000, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] c, input logic a, input logic b, input logic ck);
    @(negedge clk);
    cke = ck; a10 = a; bank_sel = b;
    case (c)
      C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      C_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      C_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      C_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      C_MRS:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
    @(posedge clk);
    #1;
  endtask

  // Automatic close on bank 0: expected close edge is the later of burst+latency and the row minimum.
  task automatic run_ap(input int bl, input int cl);
    int close_e;
    burst_len = 4'(bl); cas_lat = 2'(cl);
    cyc(C_ACT, 1'b0, 1'b0, 1'b1);
    cyc(C_RD, 1'b1, 1'b0, 1'b1);
    chk("R4 code after auto-close read", int'(bank_state[1:0]), 3);
    close_e = (1 + bl + cl > TRMIN) ? (1 + bl + cl) : TRMIN;
    for (int k = 2; k <= close_e + TRP + 1; k++) begin
      cyc(C_NOP, 1'b0, 1'b0, 1'b1);
      chk($sformatf("R4 bl=%0d cl=%0d edge %0d", bl, cl, k), int'(bank_state[1:0]),
          (k < close_e) ? 3 : (k < close_e + TRP) ? 2 : 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; cke = 1'b1; a10 = 1'b0; bank_sel = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    burst_len = 4'd2; cas_lat = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 / R11 reset state
    chk("R1 reset codes", int'(bank_state), 0);
    chk("R11 reset all_idle", int'(all_idle), 1);
    chk("R1 reset viol", int'({viol_cmd, viol_idle_only, viol_tras_max}), 0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][10:8], VEC[i][7], VEC[i][6], 1'b1);
      chk($sformatf("table row %0d codes (R2 R3 R5 R6 R7)", i), int'(bank_state), int'(VEC[i][5:2]));
      chk($sformatf("table row %0d viol_cmd (R3 R5)", i), int'(viol_cmd), int'(VEC[i][1]));
      chk($sformatf("table row %0d viol_idle_only (R10)", i), int'(viol_idle_only), int'(VEC[i][0]));
    end
    chk("R11 all_idle after table", int'(all_idle), 1);

    // R8 early precharge still closes
    cyc(C_ACT, 1'b0, 1'b0, 1'b1);
    chk("R11 all_idle low with open bank", int'(all_idle), 0);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    cyc(C_PRE, 1'b0, 1'b0, 1'b1);
    chk("R8 early precharge flagged", int'(viol_cmd), 1);
    chk("R8 early precharge closes", int'(bank_state[1:0]), 2);
    repeat (TRP) cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    chk("R7 idle after recovery", int'(bank_state), 0);

    // R4 two burst settings: row minimum decides, then burst+latency decides
    run_ap(1, 1);
    run_ap(8, 3);

    // R9 maximum row-open window on bank 1
    cyc(C_ACT, 1'b0, 1'b1, 1'b1);
    for (int n = 1; n <= TRMAX + 3; n++) begin
      cyc(C_NOP, 1'b0, 1'b0, 1'b1);
      chk($sformatf("R9 edge %0d", n), int'(viol_tras_max), (n == TRMAX + 1) ? 2 : 0);
    end
    cyc(C_PRE, 1'b0, 1'b1, 1'b1);
    chk("R6 single precharge bank1", int'(bank_state), 4'b1000);
    repeat (TRP) cyc(C_NOP, 1'b0, 1'b0, 1'b1);

    // R10 power-down entry with an open bank, then ignored command while cke low
    cyc(C_ACT, 1'b0, 1'b0, 1'b1);
    cyc(C_NOP, 1'b0, 1'b0, 1'b0);
    chk("R10 power-down with open bank", int'(viol_idle_only), 1);
    cyc(C_ACT, 1'b0, 1'b1, 1'b0);
    chk("R10 command ignored in power-down", int'(bank_state), 4'b0001);
    chk("R10 no viol while ignored", int'(viol_cmd), 0);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    cyc(C_PRE, 1'b0, 1'b0, 1'b1);
    repeat (TRP) cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    cyc(C_NOP, 1'b0, 1'b0, 1'b0);
    chk("R10 power-down legal when idle", int'(viol_idle_only), 0);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);

    // R5 / R6 precharge-all while bank 0 has a scheduled close
    burst_len = 4'd4; cas_lat = 2'd2;
    cyc(C_ACT, 1'b0, 1'b0, 1'b1);
    cyc(C_ACT, 1'b0, 1'b1, 1'b1);
    cyc(C_RD, 1'b1, 1'b0, 1'b1);
    repeat (3) cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    cyc(C_PRE, 1'b1, 1'b0, 1'b1);
    chk("R5 precharge-all hits locked bank", int'(viol_cmd), 1);
    chk("R6 precharge-all closes open bank only", int'(bank_state), 4'b1011);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    chk("R5 schedule kept", int'(bank_state), 4'b1011);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    chk("R5 hidden close on time", int'(bank_state), 4'b1010);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    chk("R7 bank1 idle", int'(bank_state), 4'b0010);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    cyc(C_NOP, 1'b0, 1'b0, 1'b1);
    chk("R7 both idle", int'(bank_state), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule